// File: doc/BRIEF.md
# Multi-Channel Host Command/Data Port

This block is a register port on the slave side. An external host bus uses it to exchange bytes with an embedded controller over several independent channels. Each channel holds three registers. The input register receives bytes from the host. The output register holds bytes for the host. The status register tells the host which buffers are occupied and whether the last byte written was a command or data.

The host side has one active-low select per channel, shared active-low read and write strobes, and one address line. When the address line is low, a host write is tagged as data and a host read returns the output register. When it is high, a host write is tagged as a command and a host read returns status. The host strobes are asynchronous to the controller. A host write takes effect on the rising edge of the write strobe, after that edge has been resynchronised into the local clock. Each write sets the channel's input-full flag and pulses a one-cycle interrupt request to the local side.

On the local side, the controller loads the output register with a per-channel write enable. That load sets the output-full flag. The controller acknowledges the input register with a per-channel read strobe, which clears the input-full flag.

Top module: `host_cmd_port`

## Requirements
- R1: After reset, every input-full, output-full, command flag, interrupt and input register is 0, and `host_d_o` reads 0 while the bus is idle.
- R2: A host write with `host_a0_i`=0 to channel n loads `host_d_i` into that channel's input register, sets its input-full flag and clears its command flag. All three are visible on the third rising clock edge after the write strobe returns high.
- R3: A host write with `host_a0_i`=1 loads the byte the same way and sets the channel's command flag to 1.
- R4: Each accepted host write raises `ibf_irq_o[n]` for exactly one cycle, in the same cycle that input-full becomes visible.
- R5: A pulse on `loc_idr_re_i[n]` clears input-full of channel n on the next edge and leaves the input register's contents unchanged.
- R6: A pulse on `loc_odr_we_i[n]` loads `loc_odr_d_i` into output register n and sets its output-full flag on that edge.
- R7: While select n, read strobe and address are low and the write strobe is high, `host_d_o` shows output register n. Output-full n clears on the third clock edge after the read strobe returns high.
- R8: With address high, a host read returns the status byte: bit 0 output-full, bit 1 input-full, bit 3 command flag, all other bits 0. A status read does not clear output-full.
- R9: While both strobes are low at once, `host_d_o` is 0. If both strobes are then released together, no register or flag changes.
- R10: With every select high, strobe activity changes nothing and `host_d_o` stays 0.
- R11: An access to one channel leaves the registers and flags of every other channel unchanged.
- R12: When a flag's set and clear events fall on the same edge, the set wins. This applies to a host write against a local read, and to a local output load against a host read clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_cs_ni | input | NCH | Per-channel host select, active low |
| host_rd_ni | input | 1 | Host read strobe, active low |
| host_wr_ni | input | 1 | Host write strobe, active low |
| host_a0_i | input | 1 | Address line: 0 data, 1 command/status |
| host_d_i | input | DW | Host write data |
| host_d_o | output | DW | Host read data |
| loc_odr_we_i | input | NCH | Local output register load, one per channel |
| loc_odr_d_i | input | DW | Local output register data |
| loc_idr_re_i | input | NCH | Local input register acknowledge, one per channel |
| loc_idr_o | output | NCH*DW | Input registers, channel n at bits n*DW +: DW |
| loc_cmd_o | output | NCH | Command flag per channel |
| loc_ibf_o | output | NCH | Input-full flag per channel |
| loc_obf_o | output | NCH | Output-full flag per channel |
| ibf_irq_o | output | NCH | One-cycle input-full interrupt per channel |

## Verification
The assertions assume that the local-side strobes are single-cycle, synchronous pulses. They also assume that the host keeps select, address and data stable from before a strobe falls until at least one clock after it rises, so that the resynchronised copies stay aligned. The bench changes every input on the falling clock edge. It holds host strobes low for three clock cycles and drops select only after the strobe has risen. The coincidence tests for R12 time the local pulse to the edge the bench calculates for the host event.

// File: rtl/hcp_pkg.sv
package hcp_pkg;
  localparam int STS_OBF = 0;
  localparam int STS_IBF = 1;
  localparam int STS_CMD = 3;

  function automatic logic [7:0] pack_status(logic obf, logic ibf, logic cmd);
    logic [7:0] s;
    s = '0;
    s[STS_OBF] = obf;
    s[STS_IBF] = ibf;
    s[STS_CMD] = cmd;
    return s;
  endfunction
endpackage

// File: rtl/hcp_sync.sv
module hcp_sync #(
  parameter int W = 8,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/hcp_decode.sv
module hcp_decode #(
  parameter int NCH = 4,
  parameter int DW = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] cs_n_i,
  input  logic           rd_n_i,
  input  logic           wr_n_i,
  input  logic           a0_i,
  input  logic [DW-1:0]  d_i,
  output logic [NCH-1:0] wr_commit_o,
  output logic [NCH-1:0] obf_clr_o,
  output logic           wr_a0_o,
  output logic [DW-1:0]  wr_d_o
);
  logic [NCH-1:0] cs_q;
  logic rd_q, wr_q, a0_q;
  logic [DW-1:0] d_q;
  logic wr_rise, rd_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q <= '1;
      rd_q <= 1'b1;
      wr_q <= 1'b1;
      a0_q <= 1'b0;
      d_q  <= '0;
    end else begin
      cs_q <= cs_n_i;
      rd_q <= rd_n_i;
      wr_q <= wr_n_i;
      a0_q <= a0_i;
      d_q  <= d_i;
    end
  end

  // strobe end counts only if the other strobe was inactive during the access
  assign wr_rise = wr_n_i & ~wr_q & rd_q;
  assign rd_rise = rd_n_i & ~rd_q & wr_q;

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    assign wr_commit_o[n] = wr_rise & ~cs_q[n];
    assign obf_clr_o[n]   = rd_rise & ~cs_q[n] & ~a0_q;
  end

  assign wr_a0_o = a0_q;
  assign wr_d_o  = d_q;
endmodule

// File: rtl/hcp_channel.sv
module hcp_channel #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_commit_i,
  input  logic          wr_a0_i,
  input  logic [DW-1:0] wr_d_i,
  input  logic          obf_clr_i,
  input  logic          odr_we_i,
  input  logic [DW-1:0] odr_d_i,
  input  logic          idr_re_i,
  output logic [DW-1:0] idr_o,
  output logic [DW-1:0] odr_o,
  output logic          ibf_o,
  output logic          obf_o,
  output logic          cmd_o,
  output logic          irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idr_o <= '0;
      odr_o <= '0;
      ibf_o <= 1'b0;
      obf_o <= 1'b0;
      cmd_o <= 1'b0;
      irq_o <= 1'b0;
    end else begin
      irq_o <= wr_commit_i;
      if (wr_commit_i) begin
        idr_o <= wr_d_i;
        cmd_o <= wr_a0_i;
      end
      // set has priority over clear
      if (wr_commit_i)   ibf_o <= 1'b1;
      else if (idr_re_i) ibf_o <= 1'b0;
      if (odr_we_i) begin
        odr_o <= odr_d_i;
        obf_o <= 1'b1;
      end else if (obf_clr_i) begin
        obf_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/host_cmd_port.sv
module host_cmd_port #(
  parameter int NCH = 4,
  parameter int DW = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NCH-1:0]    host_cs_ni,
  input  logic              host_rd_ni,
  input  logic              host_wr_ni,
  input  logic              host_a0_i,
  input  logic [DW-1:0]     host_d_i,
  output logic [DW-1:0]     host_d_o,
  input  logic [NCH-1:0]    loc_odr_we_i,
  input  logic [DW-1:0]     loc_odr_d_i,
  input  logic [NCH-1:0]    loc_idr_re_i,
  output logic [NCH*DW-1:0] loc_idr_o,
  output logic [NCH-1:0]    loc_cmd_o,
  output logic [NCH-1:0]    loc_ibf_o,
  output logic [NCH-1:0]    loc_obf_o,
  output logic [NCH-1:0]    ibf_irq_o
);
  import hcp_pkg::*;

  localparam int SW = NCH + 3 + DW;
  localparam logic [SW-1:0] SYNC_IDLE = {{NCH{1'b1}}, 1'b1, 1'b1, 1'b0, {DW{1'b0}}};

  logic [SW-1:0]  bus_s;
  logic [NCH-1:0] cs_s;
  logic           rd_s, wr_s, a0_s;
  logic [DW-1:0]  d_s;
  logic [NCH-1:0] wr_commit, obf_clr;
  logic           wr_a0;
  logic [DW-1:0]  wr_d;
  logic [DW-1:0]  odr [NCH];
  logic [DW-1:0]  sts [NCH];

  hcp_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_IDLE)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({host_cs_ni, host_rd_ni, host_wr_ni, host_a0_i, host_d_i}),
    .q_o   (bus_s)
  );

  assign {cs_s, rd_s, wr_s, a0_s, d_s} = bus_s;

  hcp_decode #(.NCH(NCH), .DW(DW)) u_dec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_n_i     (cs_s),
    .rd_n_i     (rd_s),
    .wr_n_i     (wr_s),
    .a0_i       (a0_s),
    .d_i        (d_s),
    .wr_commit_o(wr_commit),
    .obf_clr_o  (obf_clr),
    .wr_a0_o    (wr_a0),
    .wr_d_o     (wr_d)
  );

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    hcp_channel #(.DW(DW)) u_ch (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_commit_i(wr_commit[n]),
      .wr_a0_i    (wr_a0),
      .wr_d_i     (wr_d),
      .obf_clr_i  (obf_clr[n]),
      .odr_we_i   (loc_odr_we_i[n]),
      .odr_d_i    (loc_odr_d_i),
      .idr_re_i   (loc_idr_re_i[n]),
      .idr_o      (loc_idr_o[n*DW +: DW]),
      .odr_o      (odr[n]),
      .ibf_o      (loc_ibf_o[n]),
      .obf_o      (loc_obf_o[n]),
      .cmd_o      (loc_cmd_o[n]),
      .irq_o      (ibf_irq_o[n])
    );
    if (DW >= 8) begin : g_sts_w
      assign sts[n] = DW'(pack_status(loc_obf_o[n], loc_ibf_o[n], loc_cmd_o[n]));
    end else begin : g_sts_n
      assign sts[n] = pack_status(loc_obf_o[n], loc_ibf_o[n], loc_cmd_o[n])[DW-1:0];
    end
  end

  // host read path is combinational from the raw bus
  always_comb begin
    host_d_o = '0;
    if (!host_rd_ni && host_wr_ni) begin
      for (int n = 0; n < NCH; n++)
        if (!host_cs_ni[n]) host_d_o |= host_a0_i ? sts[n] : odr[n];
    end
  end
endmodule

// File: rtl/hcp_checker.sv
module hcp_checker #(
  parameter int NCH = 4,
  parameter int DW = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NCH-1:0]    loc_odr_we_i,
  input logic [NCH-1:0]    loc_idr_re_i,
  input logic [NCH*DW-1:0] loc_idr_o,
  input logic [NCH-1:0]    loc_ibf_o,
  input logic [NCH-1:0]    loc_obf_o,
  input logic [NCH-1:0]    ibf_irq_o
);
  for (genvar n = 0; n < NCH; n++) begin : g_chk
    assert_irq_with_ibf_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ibf_irq_o[n] |-> loc_ibf_o[n]);
    assert_irq_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ibf_irq_o[n] |=> !ibf_irq_o[n]);
    assert_ibf_rise_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(loc_ibf_o[n]) |-> ibf_irq_o[n]);
    assert_ibf_fall_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(loc_ibf_o[n]) |-> $past(loc_idr_re_i[n]));
    assert_obf_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      loc_odr_we_i[n] |=> loc_obf_o[n]);
    assert_obf_rise_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(loc_obf_o[n]) |-> $past(loc_odr_we_i[n]));
    assert_idr_stable_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(loc_idr_o[n*DW +: DW]) |-> ibf_irq_o[n]);
  end
endmodule

bind host_cmd_port hcp_checker #(.NCH(NCH), .DW(DW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .loc_odr_we_i(loc_odr_we_i),
  .loc_idr_re_i(loc_idr_re_i),
  .loc_idr_o   (loc_idr_o),
  .loc_ibf_o   (loc_ibf_o),
  .loc_obf_o   (loc_obf_o),
  .ibf_irq_o   (ibf_irq_o)
);

// File: tb/host_cmd_port_test.sv
module host_cmd_port_test;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCH-1:0] cs_n = '1;
  logic rd_n = 1'b1, wr_n = 1'b1, a0 = 1'b0;
  logic [DW-1:0] hd = '0, hq, od = '0;
  logic [NCH-1:0] odr_we = '0, idr_re = '0;
  logic [NCH*DW-1:0] idr;
  logic [NCH-1:0] cmd, ibf, obf, irq;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  host_cmd_port #(.NCH(NCH), .DW(DW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .host_cs_ni(cs_n), .host_rd_ni(rd_n),
    .host_wr_ni(wr_n), .host_a0_i(a0), .host_d_i(hd), .host_d_o(hq),
    .loc_odr_we_i(odr_we), .loc_odr_d_i(od), .loc_idr_re_i(idr_re),
    .loc_idr_o(idr), .loc_cmd_o(cmd), .loc_ibf_o(ibf), .loc_obf_o(obf),
    .ibf_irq_o(irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // write strobe rises at a falling edge; result visible three rising edges later
  task automatic host_write(int ch, logic a, logic [7:0] d);
    @(negedge clk);
    cs_n[ch] = 1'b0; a0 = a; hd = d; wr_n = 1'b0;
    repeat (3) @(negedge clk);
    wr_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic host_read(int ch, logic a, output logic [7:0] q);
    @(negedge clk);
    cs_n[ch] = 1'b0; a0 = a; rd_n = 1'b0;
    repeat (2) @(negedge clk);
    q = hq;
    rd_n = 1'b1;
    repeat (3) @(negedge clk);
    cs_n = '1;
  endtask

  task automatic loc_write(int ch, logic [7:0] d);
    @(negedge clk);
    odr_we[ch] = 1'b1; od = d;
    @(negedge clk);
    odr_we = '0;
  endtask

  task automatic loc_read(int ch);
    @(negedge clk);
    idr_re[ch] = 1'b1;
    @(negedge clk);
    idr_re = '0;
  endtask

  task automatic t_reset;
    check("R1 ibf", 32'(ibf), 0);
    check("R1 obf", 32'(obf), 0);
    check("R1 cmd", 32'(cmd), 0);
    check("R1 irq", 32'(irq), 0);
    check("R1 idr", idr, 0);
    check("R1 host_d_o", 32'(hq), 0);
  endtask

  task automatic t_data_write;
    host_write(0, 1'b0, 8'h5A);
    check("R2 idr", 32'(idr[7:0]), 32'h5A);
    check("R2 ibf", 32'(ibf[0]), 1);
    check("R2 cmd", 32'(cmd[0]), 0);
    check("R4 irq high", 32'(irq[0]), 1);
    check("R11 other ibf", 32'(ibf[3:1]), 0);
    cs_n = '1;
    @(negedge clk);
    check("R4 irq one cycle", 32'(irq), 0);
  endtask

  task automatic t_cmd_write;
    logic [7:0] q;
    host_write(2, 1'b1, 8'hD1);
    cs_n = '1;
    check("R3 idr", 32'(idr[23:16]), 32'hD1);
    check("R3 cmd", 32'(cmd[2]), 1);
    host_read(2, 1'b1, q);
    check("R8 status ibf+cmd", 32'(q), 32'h0A);
    check("R11 ch0 idr kept", 32'(idr[7:0]), 32'h5A);
  endtask

  task automatic t_local_read;
    loc_read(0);
    check("R5 ibf cleared", 32'(ibf[0]), 0);
    check("R5 idr kept", 32'(idr[7:0]), 32'h5A);
  endtask

  task automatic t_out_path;
    logic [7:0] q;
    loc_write(1, 8'h3C);
    check("R6 obf set", 32'(obf[1]), 1);
    host_read(1, 1'b1, q);
    check("R8 status obf", 32'(q), 32'h01);
    check("R8 status read keeps obf", 32'(obf[1]), 1);
    host_read(1, 1'b0, q);
    check("R7 data read", 32'(q), 32'h3C);
    check("R7 obf cleared", 32'(obf[1]), 0);
  endtask

  task automatic t_both_low;
    loc_write(3, 8'h44);
    @(negedge clk);
    cs_n[3] = 1'b0; a0 = 1'b0; hd = 8'hFF; wr_n = 1'b0; rd_n = 1'b0;
    @(negedge clk);
    check("R9 host_d_o zero", 32'(hq), 0);
    repeat (2) @(negedge clk);
    wr_n = 1'b1; rd_n = 1'b1;
    repeat (4) @(negedge clk);
    cs_n = '1;
    check("R9 ibf unchanged", 32'(ibf[3]), 0);
    check("R9 idr unchanged", 32'(idr[31:24]), 0);
    check("R9 obf unchanged", 32'(obf[3]), 1);
  endtask

  task automatic t_idle;
    logic [NCH-1:0] ibf0;
    ibf0 = ibf;
    @(negedge clk);
    a0 = 1'b0; hd = 8'h77; wr_n = 1'b0;
    repeat (3) @(negedge clk);
    wr_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R10 ibf unchanged", 32'(ibf), 32'(ibf0));
    check("R10 irq quiet", 32'(irq), 0);
    rd_n = 1'b0;
    @(negedge clk);
    check("R10 host_d_o zero", 32'(hq), 0);
    rd_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_set_wins;
    // host write commits at the third edge after wr rises; local read on that edge
    @(negedge clk);
    cs_n[1] = 1'b0; a0 = 1'b0; hd = 8'h21; wr_n = 1'b0;
    repeat (3) @(negedge clk);
    wr_n = 1'b1;
    repeat (2) @(negedge clk);
    idr_re[1] = 1'b1;
    @(negedge clk);
    idr_re = '0;
    cs_n = '1;
    check("R12 ibf set wins", 32'(ibf[1]), 1);
    // host read clear on the same edge as a local load
    @(negedge clk);
    cs_n[1] = 1'b0; a0 = 1'b0; rd_n = 1'b0;
    repeat (2) @(negedge clk);
    rd_n = 1'b1;
    repeat (2) @(negedge clk);
    odr_we[1] = 1'b1; od = 8'h99;
    @(negedge clk);
    odr_we = '0;
    cs_n = '1;
    check("R12 obf set wins", 32'(obf[1]), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_data_write();
    t_cmd_write();
    t_local_read();
    t_out_path();
    t_both_low();
    t_idle();
    t_set_wins();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule